// File: doc/BRIEF.md
# Serial Control and Successive-Approximation Sequencer for a Four-Input Converter

This block is the digital half of a four-input successive-approximation analog-to-digital converter. A host frames each transaction with an active-low chip select. It supplies a serial clock and sends a control byte on the serial data input. The block finds the start of that byte and decodes from it the input multiplexer setting, the power policy and the conversion-clock mode. Once the last control bit is in, the block runs a bit-by-bit search against an external comparator, making one decision per serial clock. Each decided bit goes out on the serial data output as soon as it is known.

The block drives the trial code that feeds the capacitor DAC. The analog side returns a single comparator bit telling whether the sampled input is at or above that trial. The serial outputs and the busy flag come with separate output-enable signals, so the pads can be tri-stated while the chip is not selected. The whole design runs on one system clock. The serial clock and chip select are sampled in that clock domain and their edges are detected there.

A frame is eight control clocks plus one clock per result bit. The next start bit may be clocked in while the last result bit is still on the output, which gives 24 clocks per frame at 16-bit resolution. If the host keeps clocking instead, the output carries zeros.

Top module: `sar_serial_ctl`

## Requirements
- R1: After synchronous reset, with chip select high, these outputs are all 0: `sdo_oe`, `busy_oe`, `busy`, `sample`, `hold`, `mux_pos`, `mux_diff`, `int_clk` and `pwr_on`. Reset selects the power-down-between-conversions policy.
- R2: While the block waits for a frame, low bits on `sdi` are ignored. The first high bit sampled on a serial-clock rise is the start bit. It is followed, most significant first, by A2, A1, A0, one don't-care bit, the SGL/DIF bit, PD1 and PD0.
- R3: `sample` rises on the serial-clock rise that carries A0, the fourth bit of the byte. On the eighth rise `sample` falls and `hold` rises. The two are never high together.
- R4: `busy` goes high on the serial-clock fall that follows the eighth control bit. It goes low on the next fall, so it lasts exactly one serial clock.
- R5: The trial code starts with only its top bit set. Each later serial-clock rise keeps or clears the current trial bit according to `cmp_in` (1 keeps it) and sets the next lower bit. Each decision appears on `sdo` at the following fall, most significant bit first, so the serial word is the straight-binary code of the input.
- R6: After the least significant result bit, every further serial-clock fall drives `sdo` to 0 until another conversion produces a decision.
- R7: The start bit of the next control byte is accepted on the rise right after the fall that outputs the last result bit. Back-to-back frames therefore take RES_BITS+8 serial clocks each.
- R8: `sdo_oe` and `busy_oe` are 1 exactly while chip select is low, one system clock later. `busy` reads 0 after chip select falls. Raising chip select abandons the frame in progress.
- R9: With SGL/DIF high (single-ended against the common input), A2..A1..A0 selects the channel: 001 gives channel 0, 101 gives 1, 010 gives 2 and 110 gives 3. `mux_pos` shows that channel from the A0 rise on, and `mux_diff` is 0.
- R10: With SGL/DIF low, the same four codes select a differential pair. `mux_diff` becomes 1, and the negative input is `mux_pos` XOR 1 (0/1 and 2/3 pairs).
- R11: The codes 000, 011, 100 and 111 leave `mux_pos` and `mux_diff` unchanged.
- R12: PD1 PD0 = 11 or 10 keeps `pwr_on` high between frames. 00 raises `pwr_on` only while `sample` or `hold` is high. 01 changes nothing.
- R13: PD 10 requests the internal conversion clock and 11 the external one. `int_clk` takes the requested value only when the conversion started by that byte ends. 00 and 01 keep the current request.
- R14: While `shdn_n` is low, `pwr_on` is 0 from the next system clock on, whatever the power policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial control input, sampled on sclk rise |
| shdn_n | input | 1 | Active-low forced shutdown |
| cmp_in | input | 1 | Comparator result for the current trial code |
| sdo | output | 1 | Serial result output, updated on sclk fall |
| sdo_oe | output | 1 | Output enable for sdo |
| busy | output | 1 | One-serial-clock conversion start flag |
| busy_oe | output | 1 | Output enable for busy |
| sample | output | 1 | Acquisition in progress |
| hold | output | 1 | Sample held, conversion in progress |
| mux_pos | output | 2 | Selected positive input channel |
| mux_diff | output | 1 | 1: differential pair, 0: single-ended |
| dac_code | output | RES_BITS | Trial code for the capacitor DAC |
| pwr_on | output | 1 | Analog section power request |
| int_clk | output | 1 | Internal conversion clock in effect |

## Verification
The bench builds the block with RES_BITS = 8 and holds each serial-clock phase for three system clocks. At that width a sweep over every input level becomes practical: all 256 comparator thresholds run as back-to-back 16-clock frames, and each serial word must equal its threshold. The same small frame makes it cheap to walk all eight channel codes in both input modes, every power code and both clock-mode transitions. It also adds an extended zero-fill frame and an aborted frame.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

  // control byte layout (count of bits already received when a field arrives)
  localparam int CTRL_W      = 8;
  localparam int CNT_W       = $clog2(CTRL_W);
  localparam int CHAN_DONE   = 3;  // A0 arrives as fourth bit
  localparam int MODE_BIT    = 5;  // SGL/DIF arrives as sixth bit
  localparam int LAST_BIT    = CTRL_W - 1;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_CTRL = 2'd1,
    RX_CONV = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    PD_AUTO   = 2'b00,
    PD_RSVD   = 2'b01,
    PD_INTCLK = 2'b10,
    PD_EXTCLK = 2'b11
  } pd_code_e;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall
);

  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  // edges only count while the block is selected
  always_comb begin
    sclk_rise = sclk & ~sclk_q & ~cs_n;
    sclk_fall = ~sclk & sclk_q & ~cs_n;
  end

endmodule

// File: rtl/sar_ctrl_rx.sv
module sar_ctrl_rx
  import sar_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rise,
  input  logic       sdi,
  input  logic       conv_done,
  output logic       byte_done,
  output pd_code_e   pd_code,
  output logic       sample,
  output logic       hold,
  output logic [1:0] mux_pos,
  output logic       mux_diff
);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sh;
  logic             chan_ok;
  logic             code_valid;
  logic [1:0]       code_chan;

  // sh holds {A2,A1} while sdi carries A0
  always_comb begin
    code_valid = sh[0] ^ sdi;
    code_chan  = {sh[0], sh[1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      sh        <= '0;
      chan_ok   <= 1'b0;
      byte_done <= 1'b0;
      pd_code   <= PD_AUTO;
      sample    <= 1'b0;
      hold      <= 1'b0;
      mux_pos   <= '0;
      mux_diff  <= 1'b0;
    end else if (cs_n) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      chan_ok   <= 1'b0;
      byte_done <= 1'b0;
      sample    <= 1'b0;
      hold      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (rise && sdi) begin
            st  <= RX_CTRL;
            cnt <= CNT_W'(1);
            sh  <= '0;
          end
        end
        RX_CTRL: begin
          if (rise) begin
            sh  <= {sh[0], sdi};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(CHAN_DONE)) begin
              sample  <= 1'b1;
              chan_ok <= code_valid;
              if (code_valid) mux_pos <= code_chan;
            end
            if (cnt == CNT_W'(MODE_BIT) && chan_ok) mux_diff <= ~sdi;
            if (cnt == CNT_W'(LAST_BIT)) begin
              pd_code   <= pd_code_e'({sh[0], sdi});
              byte_done <= 1'b1;
              sample    <= 1'b0;
              hold      <= 1'b1;
              st        <= RX_CONV;
            end
          end
        end
        RX_CONV: begin
          if (conv_done) begin
            hold <= 1'b0;
            st   <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  p_sample_hold_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(sample && hold));

  p_hold_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !cs_n) |-> hold);

endmodule

// File: rtl/sar_succ_approx.sv
module sar_succ_approx #(
  parameter int RES_BITS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                rise,
  input  logic                fall,
  input  logic                start,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] trial,
  output logic                busy,
  output logic                sdo,
  output logic                conv_done
);

  localparam int IW = (RES_BITS > 2) ? $clog2(RES_BITS) : 1;
  localparam logic [IW-1:0] TOP = IW'(RES_BITS - 1);

  logic          arm;
  logic          active;
  logic [IW-1:0] idx;
  logic          pend;
  logic          pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      trial     <= '0;
      arm       <= 1'b0;
      active    <= 1'b0;
      idx       <= '0;
      pend      <= 1'b0;
      pend_v    <= 1'b0;
      busy      <= 1'b0;
      sdo       <= 1'b0;
      conv_done <= 1'b0;
    end else if (cs_n) begin
      arm       <= 1'b0;
      active    <= 1'b0;
      pend_v    <= 1'b0;
      busy      <= 1'b0;
      sdo       <= 1'b0;
      conv_done <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (start) arm <= 1'b1;
      if (fall) begin
        sdo    <= pend_v & pend;
        pend_v <= 1'b0;
        if (arm) begin
          busy   <= 1'b1;
          arm    <= 1'b0;
          active <= 1'b1;
          idx    <= TOP;
          trial  <= {1'b1, {(RES_BITS-1){1'b0}}};
        end else begin
          busy <= 1'b0;
        end
      end
      if (rise && active) begin
        trial[idx] <= cmp_in;
        pend       <= cmp_in;
        pend_v     <= 1'b1;
        if (idx != '0) begin
          trial[idx - 1'b1] <= 1'b1;
          idx               <= idx - 1'b1;
        end else begin
          active    <= 1'b0;
          conv_done <= 1'b1;
        end
      end
    end
  end

  p_busy_one_clock_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && fall) |=> !busy);

  p_first_trial_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($countones(trial) == 1 && trial[RES_BITS-1]));

endmodule

// File: rtl/sar_pwr_mode.sv
module sar_pwr_mode
  import sar_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  pd_code_e pd_code,
  input  logic     conv_done,
  input  logic     shdn_n,
  input  logic     sample,
  input  logic     hold,
  output logic     pwr_on,
  output logic     int_clk
);

  logic auto_pd;
  logic req_int;

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_pd <= 1'b1;
      req_int <= 1'b0;
      int_clk <= 1'b0;
      pwr_on  <= 1'b0;
    end else begin
      if (load) begin
        unique case (pd_code)
          PD_EXTCLK: begin auto_pd <= 1'b0; req_int <= 1'b0; end
          PD_INTCLK: begin auto_pd <= 1'b0; req_int <= 1'b1; end
          PD_AUTO:   auto_pd <= 1'b1;
          default:   ;
        endcase
      end
      if (conv_done) int_clk <= req_int;
      pwr_on <= shdn_n & (~auto_pd | sample | hold);
    end
  end

  p_shdn_off_r14: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> !pwr_on);

  p_clk_mode_at_end_r13: assert property (@(posedge clk) disable iff (rst)
    (int_clk != $past(int_clk)) |-> $past(conv_done));

endmodule

// File: rtl/sar_serial_ctl.sv
module sar_serial_ctl
  import sar_ctl_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdi,
  input  logic                shdn_n,
  input  logic                cmp_in,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                busy,
  output logic                busy_oe,
  output logic                sample,
  output logic                hold,
  output logic [1:0]          mux_pos,
  output logic                mux_diff,
  output logic [RES_BITS-1:0] dac_code,
  output logic                pwr_on,
  output logic                int_clk
);

  logic     rise;
  logic     fall;
  logic     byte_done;
  logic     conv_done;
  pd_code_e pd_code;

  sar_edge_det u_edge (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sclk_rise (rise),
    .sclk_fall (fall)
  );

  sar_ctrl_rx u_rx (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rise      (rise),
    .sdi       (sdi),
    .conv_done (conv_done),
    .byte_done (byte_done),
    .pd_code   (pd_code),
    .sample    (sample),
    .hold      (hold),
    .mux_pos   (mux_pos),
    .mux_diff  (mux_diff)
  );

  sar_succ_approx #(.RES_BITS(RES_BITS)) u_sar (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rise      (rise),
    .fall      (fall),
    .start     (byte_done),
    .cmp_in    (cmp_in),
    .trial     (dac_code),
    .busy      (busy),
    .sdo       (sdo),
    .conv_done (conv_done)
  );

  sar_pwr_mode u_pwr (
    .clk       (clk),
    .rst       (rst),
    .load      (byte_done),
    .pd_code   (pd_code),
    .conv_done (conv_done),
    .shdn_n    (shdn_n),
    .sample    (sample),
    .hold      (hold),
    .pwr_on    (pwr_on),
    .int_clk   (int_clk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_oe  <= 1'b0;
      busy_oe <= 1'b0;
    end else begin
      sdo_oe  <= ~cs_n;
      busy_oe <= ~cs_n;
    end
  end

  p_oe_follows_cs_r8: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!sdo_oe && !busy_oe));

endmodule

// File: tb/tb_sar_serial_ctl.sv
module tb_sar_serial_ctl;

  localparam int RB = 8;
  localparam int H  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, shdn_n = 1'b1;
  logic cmp_in;
  logic sdo, sdo_oe, busy, busy_oe, sample, hold, mux_diff, pwr_on, int_clk;
  logic [1:0] mux_pos;
  logic [RB-1:0] dac_code;
  logic [RB-1:0] target = '0;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic mid_pwr, mid_int;

  always #4 clk = ~clk;

  // comparator model: input level at or above trial keeps the bit
  assign cmp_in = (dac_code <= target);

  sar_serial_ctl #(.RES_BITS(RB)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .shdn_n(shdn_n), .cmp_in(cmp_in), .sdo(sdo), .sdo_oe(sdo_oe),
    .busy(busy), .busy_oe(busy_oe), .sample(sample), .hold(hold),
    .mux_pos(mux_pos), .mux_diff(mux_diff), .dac_code(dac_code),
    .pwr_on(pwr_on), .int_clk(int_clk)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one serial clock: rise then fall; outputs read after the fall
  task automatic bitc(input logic d);
    sdi = d; sclk = 1'b1; tick(H);
    sclk = 1'b0; tick(H);
  endtask

  task automatic frame(input logic [2:0] a, input logic sgl, input logic [1:0] pd,
                       input logic [RB-1:0] tgt, output logic [RB-1:0] got);
    logic [7:0] cb;
    cb = {1'b1, a, 1'b0, sgl, pd};
    target = tgt;
    for (int i = 7; i >= 0; i--) begin
      bitc(cb[i]);
      case (8 - i)
        3: check("R3 sample before A0", sample, 0);
        4: check("R3 sample at A0", sample, 1);
        5: begin mid_pwr = pwr_on; mid_int = int_clk; end
        7: check("R4 busy before byte end", busy, 0);
        8: begin
             check("R4 busy after byte", busy, 1);
             check("R3 hold after byte", hold, 1);
             check("R3 sample off in hold", sample, 0);
           end
        default: ;
      endcase
    end
    for (int j = 0; j < RB; j++) begin
      bitc(1'b0);
      got[RB-1-j] = sdo;
      if (j == 0) check("R4 busy one clock", busy, 0);
    end
  endtask

  logic [RB-1:0] got;
  logic [1:0] exp_pos;
  logic exp_diff;

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check("R1 sdo_oe", sdo_oe, 0);
    check("R1 busy_oe", busy_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 sample/hold", {sample, hold}, 0);
    check("R1 mux", {mux_pos, mux_diff}, 0);
    check("R1 int_clk", int_clk, 0);
    check("R1 pwr_on", pwr_on, 0);

    // R8 select enables the pads
    cs_n = 1'b0; tick(2);
    check("R8 oe on select", {sdo_oe, busy_oe}, 2'b11);
    check("R8 busy low after select", busy, 0);

    // R2 leading zeros ignored
    for (int k = 0; k < 5; k++) bitc(1'b0);
    check("R2 idle on zeros", {sample, hold, busy}, 0);
    frame(3'b101, 1'b1, 2'b11, 8'hA5, got);
    check("R2 result after zeros", got, 8'hA5);

    // R5 R7 exhaustive sweep, back-to-back overlapping frames
    for (int v = 0; v < 256; v++) begin
      frame(3'b001, 1'b1, 2'b11, RB'(v), got);
      check("R5 R7 sweep result", got, v);
    end

    // R6 zero fill after the LSB
    frame(3'b010, 1'b1, 2'b11, 8'hFF, got);
    check("R6 full-scale word", got, 8'hFF);
    for (int k = 0; k < RB; k++) begin
      bitc(1'b0);
      check("R6 zero fill", sdo, 0);
    end

    // R9 R11 single-ended codes, R10 R11 differential codes
    exp_pos = mux_pos; exp_diff = mux_diff;
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        frame(3'(c), (m == 0), 2'b11, 8'h3C, got);
        if (c[1] ^ c[0]) begin exp_pos = {c[1], c[2]}; exp_diff = (m == 1); end
        check(m == 0 ? "R9 R11 single-ended mux" : "R10 R11 differential mux",
              {mux_pos, mux_diff}, {exp_pos, exp_diff});
      end
    end

    // R12 power policy
    frame(3'b001, 1'b1, 2'b11, 8'h11, got);
    check("R12 always on idle", pwr_on, 1);
    frame(3'b001, 1'b1, 2'b00, 8'h22, got);
    check("R12 auto off idle", pwr_on, 0);
    frame(3'b001, 1'b1, 2'b00, 8'h22, got);
    check("R12 auto on while sampling", mid_pwr, 1);
    frame(3'b001, 1'b1, 2'b01, 8'h33, got);
    check("R12 reserved keeps policy", pwr_on, 0);

    // R13 clock mode change at end of conversion
    frame(3'b001, 1'b1, 2'b10, 8'h44, got);
    check("R13 old mode during frame", mid_int, 0);
    check("R13 internal after frame", int_clk, 1);
    check("R12 internal mode powered", pwr_on, 1);
    frame(3'b001, 1'b1, 2'b00, 8'h55, got);
    check("R13 auto keeps mode", int_clk, 1);
    frame(3'b001, 1'b1, 2'b11, 8'h66, got);
    check("R13 old mode mid frame", mid_int, 1);
    check("R13 external after frame", int_clk, 0);
    check("R5 result 66", got, 8'h66);

    // R14 forced shutdown
    shdn_n = 1'b0; tick(2);
    check("R14 shutdown forces off", pwr_on, 0);
    shdn_n = 1'b1; tick(2);
    check("R14 release restores", pwr_on, 1);

    // R8 abort by chip select, then a clean frame
    bitc(1'b1); bitc(1'b1); bitc(1'b0);
    cs_n = 1'b1; tick(2);
    check("R8 oe off when deselected", {sdo_oe, busy_oe}, 0);
    check("R8 abort clears sample", sample, 0);
    cs_n = 1'b0; tick(2);
    frame(3'b110, 1'b1, 2'b11, 8'h81, got);
    check("R8 frame after abort", got, 8'h81);
    check("R9 channel 3 after abort", mux_pos, 2'd3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule